// File: doc/BRIEF.md
# Clock Failure Detector with Automatic Failover

This block watches a fast main oscillator clock from a free-running, slower internal safe clock. When the main clock stops toggling, the system clock output moves to the safe clock without any shortened pulse. Once the main clock has proven itself stable again, the output returns to it with no software action. A sticky status flag records that the system ran from the safe clock, and an interrupt request is raised from that flag when software has enabled it.

Main-clock activity is tracked by a request/echo toggle handshake. The safe domain flips a request bit. The main domain synchronizes it and sends it back as an echo. Each completed round trip counts as evidence of life. A miss counter in the safe domain runs between completed round trips. When it reaches a programmable limit, failure is declared. A return to the main clock needs a fixed count of back-to-back completed round trips with no expiry in between.

All configuration and flag accesses are synchronous to the safe clock. The halt input stands for the deepest power mode. It disables the safe oscillator and freezes the block, and configuration survives it unless a reset arrives during halt. The wait input only enables the wake request.

Top module: `clk_fail_guard`

## Requirements
- R1: During and right after reset the safe clock is selected (`on_safe_o`=1), `flag_o`=1, `irq_o`=0, `wake_o`=0, `safe_osc_en_o`=1, the interrupt enable is 0 and the miss limit is `LIM_DEF` (16).
- R2: The block returns to the main clock (`on_safe_o` falls) only after `QUAL_CNT` (8) consecutive completed handshakes. This happens automatically, at least `QUAL_CNT` safe cycles after the main clock starts and at most 4*`QUAL_CNT`+10.
- R3: When no handshake completes for `lim` safe cycles, `on_safe_o` rises. Measured from the main clock stopping, this takes between `lim` and `lim`+7 safe cycles.
- R4: A main-clock gap at least 12 safe cycles shorter than `lim` never causes failover.
- R5: A write (`cfg_we_i`=1 on a safe-clock edge) loads `cfg_irq_en_i` and `cfg_lim_i`. A limit below `LIM_MIN` (8) is stored as `LIM_MIN`.
- R6: `sys_clk_o` follows the selected source. Neither of its phases is ever shorter than the shorter input half period, and the two source enables are never on together.
- R7: `flag_o` is set in the safe cycle after `on_safe_o` is seen high. A pulse on `flag_clr_i` clears it only while `on_safe_o`=0; otherwise the pulse is ignored.
- R8: `irq_o` is high exactly when `flag_o` and the stored interrupt enable are both 1.
- R9: `wake_o` equals `irq_o` while `wait_i`=1 and is 0 otherwise. `wait_i` has no other effect.
- R10: While `halt_i`=1, `safe_osc_en_o`=0, no failover is declared, and configuration writes and flag clears are ignored.
- R11: After `halt_i` falls without a reset, the earlier configuration is still in force. A reset during halt restores the defaults of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| main_clk_i | input | 1 | Main oscillator clock under watch |
| safe_clk_i | input | 1 | Free-running internal safe clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt power mode, safe-clock synchronous |
| wait_i | input | 1 | Wait power mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_irq_en_i | input | 1 | Interrupt enable value to write |
| cfg_lim_i | input | LIM_W | Miss limit in safe cycles to write |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| sys_clk_o | output | 1 | Glitch-free system clock |
| safe_osc_en_o | output | 1 | Safe oscillator enable |
| on_safe_o | output | 1 | Safe clock selected |
| flag_o | output | 1 | Sticky safe-clock status flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request out of wait mode |

## Verification
The hardest state to reach from the ports is a halt that overlaps a dead main clock, followed by a halt exit. Configuration must survive that exit, and a write issued during halt must have left no trace. The bench stops the main clock only after entering halt and holds it stopped for longer than the miss limit. It also tries a write while halted. It then releases halt and checks both the detection delay and the interrupt against the limit and enable written before halt. Randomized limits, sub-limit gaps and wait levels are mixed with these directed steps, and a monitor times every phase of the system clock.

// File: rtl/cfd_pkg.sv
`timescale 1ns/1ps
package cfd_pkg;
  parameter int unsigned LIM_W = 8;
  typedef logic [LIM_W-1:0] lim_t;
  typedef struct packed {
    logic irq_en;
    lim_t lim;
  } cfg_t;
endpackage

// File: rtl/cfd_sync.sv
`timescale 1ns/1ps
module cfd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= chain[s];
    end
    assign chain[s+1] = q;
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/cfd_activity_mon.sv
`timescale 1ns/1ps
module cfd_activity_mon import cfd_pkg::*; #(
  parameter int unsigned QUAL_CNT    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic safe_clk_i,
  input  logic main_clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  lim_t lim_i,
  output logic use_safe_o
);
  localparam int unsigned QW = $clog2(QUAL_CNT + 1);
  localparam logic [QW-1:0] GOOD_LAST = QW'(QUAL_CNT - 1);

  logic          req_q, echo_m, ack_s, alive, expire;
  lim_t          miss_q;
  logic [QW-1:0] good_q;

  // request travels into main domain and comes back
  cfd_sync #(.STAGES(SYNC_STAGES)) u_echo (
    .clk_i(main_clk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(echo_m));
  cfd_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk_i(safe_clk_i), .rst_ni(rst_ni), .d_i(echo_m), .q_o(ack_s));

  assign alive  = (ack_s == req_q) && !halt_i;
  assign expire = ({1'b0, miss_q} + 1'b1) >= {1'b0, lim_i};

  always_ff @(posedge safe_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      miss_q     <= '0;
      good_q     <= '0;
      use_safe_o <= 1'b1;
    end else if (halt_i) begin
      miss_q <= '0;
      good_q <= '0;
    end else if (alive) begin
      req_q  <= ~req_q;
      miss_q <= '0;
      if (use_safe_o) begin
        if (good_q == GOOD_LAST) begin
          use_safe_o <= 1'b0;
          good_q     <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else if (expire) begin
      use_safe_o <= 1'b1;
      good_q     <= '0;
    end else begin
      miss_q <= miss_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfd_glitchless_mux.sv
`timescale 1ns/1ps
module cfd_glitchless_mux (
  input  logic main_clk_i,
  input  logic safe_clk_i,
  input  logic rst_ni,
  input  logic use_safe_i,
  output logic clk_o,
  output logic main_on_o,
  output logic safe_on_o
);
  localparam int unsigned N_SRC    = 2;
  localparam int unsigned IDX_MAIN = 0;
  localparam int unsigned IDX_SAFE = 1;

  logic [N_SRC-1:0] src_clk, want, arst_n, en, gated;

  assign src_clk = {safe_clk_i, main_clk_i};
  assign want    = {use_safe_i, !use_safe_i};
  // a dead main clock cannot drop its own enable: clear it from the safe side
  assign arst_n  = {rst_ni, rst_ni & !use_safe_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_leg
    logic s1_q, en_q, req;
    assign req = want[g] & ~en[N_SRC-1-g];
    always_ff @(posedge src_clk[g] or negedge arst_n[g]) begin
      if (!arst_n[g]) s1_q <= 1'b0;
      else            s1_q <= req;
    end
    always_ff @(negedge src_clk[g] or negedge arst_n[g]) begin
      if (!arst_n[g]) en_q <= 1'b0;
      else            en_q <= s1_q;
    end
    assign en[g]    = en_q;
    assign gated[g] = src_clk[g] & en_q;
  end

  assign clk_o     = |gated;
  assign main_on_o = en[IDX_MAIN];
  assign safe_on_o = en[IDX_SAFE];
endmodule

// File: rtl/cfd_ctrl_regs.sv
`timescale 1ns/1ps
module cfd_ctrl_regs import cfd_pkg::*; #(
  parameter int unsigned LIM_DEF = 16,
  parameter int unsigned LIM_MIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic we_i,
  input  logic irq_en_i,
  input  lim_t lim_i,
  input  logic clr_i,
  input  logic use_safe_i,
  output cfg_t cfg_o,
  output logic flag_o
);
  localparam lim_t DEF_LIM = lim_t'(LIM_DEF);
  localparam lim_t MIN_LIM = lim_t'(LIM_MIN);

  lim_t lim_fix;
  assign lim_fix = (lim_i < MIN_LIM) ? MIN_LIM : lim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.irq_en <= 1'b0;
      cfg_o.lim    <= DEF_LIM;
    end else if (we_i && !halt_i) begin
      cfg_o.irq_en <= irq_en_i;
      cfg_o.lim    <= lim_fix;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_o <= 1'b1;
    else if (use_safe_i)          flag_o <= 1'b1;
    else if (clr_i && !halt_i)    flag_o <= 1'b0;
  end
endmodule

// File: rtl/clk_fail_guard.sv
`timescale 1ns/1ps
module clk_fail_guard import cfd_pkg::*; #(
  parameter int unsigned LIM_DEF     = 16,
  parameter int unsigned LIM_MIN     = 8,
  parameter int unsigned QUAL_CNT    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             main_clk_i,
  input  logic             safe_clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             wait_i,
  input  logic             cfg_we_i,
  input  logic             cfg_irq_en_i,
  input  logic [LIM_W-1:0] cfg_lim_i,
  input  logic             flag_clr_i,
  output logic             sys_clk_o,
  output logic             safe_osc_en_o,
  output logic             on_safe_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  cfg_t cfg_q;
  logic use_safe, main_on, safe_on;

  cfd_activity_mon #(.QUAL_CNT(QUAL_CNT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .safe_clk_i(safe_clk_i), .main_clk_i(main_clk_i), .rst_ni(rst_ni),
    .halt_i(halt_i), .lim_i(cfg_q.lim), .use_safe_o(use_safe));

  cfd_ctrl_regs #(.LIM_DEF(LIM_DEF), .LIM_MIN(LIM_MIN)) u_regs (
    .clk_i(safe_clk_i), .rst_ni(rst_ni), .halt_i(halt_i), .we_i(cfg_we_i),
    .irq_en_i(cfg_irq_en_i), .lim_i(cfg_lim_i), .clr_i(flag_clr_i),
    .use_safe_i(use_safe), .cfg_o(cfg_q), .flag_o(flag_o));

  cfd_glitchless_mux u_mux (
    .main_clk_i(main_clk_i), .safe_clk_i(safe_clk_i), .rst_ni(rst_ni),
    .use_safe_i(use_safe), .clk_o(sys_clk_o), .main_on_o(main_on),
    .safe_on_o(safe_on));

  assign on_safe_o     = use_safe;
  assign safe_osc_en_o = !halt_i;
  assign irq_o         = flag_o & cfg_q.irq_en;
  assign wake_o        = irq_o & wait_i;
endmodule

// File: rtl/cfd_checker.sv
`timescale 1ns/1ps
module cfd_checker import cfd_pkg::*; #(
  parameter int unsigned LIM_MIN = 8
) (
  input logic safe_clk_i,
  input logic main_clk_i,
  input logic rst_ni,
  input logic halt_i,
  input logic on_safe_o,
  input logic flag_o,
  input logic main_on,
  input logic safe_on,
  input cfg_t cfg_q
);
  assert_sel_exclusive_safe_R6: assert property (@(posedge safe_clk_i) disable iff (!rst_ni)
    !(main_on && safe_on));
  assert_sel_exclusive_main_R6: assert property (@(posedge main_clk_i) disable iff (!rst_ni)
    !(main_on && safe_on));
  assert_flag_sets_R7: assert property (@(posedge safe_clk_i) disable iff (!rst_ni)
    on_safe_o |=> flag_o);
  assert_halt_no_failover_R10: assert property (@(posedge safe_clk_i) disable iff (!rst_ni)
    (halt_i && !on_safe_o) |=> !on_safe_o);
  assert_halt_cfg_frozen_R10: assert property (@(posedge safe_clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(cfg_q));
  assert_lim_floor_R5: assert property (@(posedge safe_clk_i) disable iff (!rst_ni)
    cfg_q.lim >= lim_t'(LIM_MIN));
endmodule

bind clk_fail_guard cfd_checker #(.LIM_MIN(LIM_MIN)) u_chk (.*);

// File: tb/tb_clk_fail_guard.sv
`timescale 1ns/1ps
module tb_clk_fail_guard;
  localparam int MAIN_PER = 10;
  localparam int SAFE_PER = 26;
  localparam int LIM_DEF  = 16;
  localparam int LIM_MIN  = 8;
  localparam int QUAL     = 8;
  localparam int WD_NS    = 1500000;

  logic main_clk = 0, safe_clk = 0, rst_ni = 1, main_run = 1;
  logic halt = 0, wait_m = 0, we = 0, irq_en_w = 0, clr = 0;
  logic [7:0] lim_w = 0;
  logic sys_clk, osc_en, on_safe, flag, irq, wake;
  int checks = 0, fails = 0, runts = 0, sys_edges = 0;
  realtime last_t = 0;
  bit mon_on = 0;

  clk_fail_guard dut (
    .main_clk_i(main_clk), .safe_clk_i(safe_clk), .rst_ni(rst_ni), .halt_i(halt),
    .wait_i(wait_m), .cfg_we_i(we), .cfg_irq_en_i(irq_en_w), .cfg_lim_i(lim_w),
    .flag_clr_i(clr), .sys_clk_o(sys_clk), .safe_osc_en_o(osc_en),
    .on_safe_o(on_safe), .flag_o(flag), .irq_o(irq), .wake_o(wake));

  initial forever begin
    #(MAIN_PER/2);
    if (main_run) main_clk = ~main_clk; else main_clk = 0;
  end
  initial forever #(SAFE_PER/2) safe_clk = ~safe_clk;

  always @(posedge sys_clk) sys_edges++;
  always @(sys_clk) begin
    if (mon_on && ($realtime - last_t) < MAIN_PER/2) runts++;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string rid, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
    end
  endtask

  function automatic int eff_lim(input int l);
    return (l < LIM_MIN) ? LIM_MIN : l;
  endfunction

  function automatic int edges_exp(input int ncyc, input int per);
    return (ncyc * SAFE_PER) / per;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge safe_clk);
    #2;
  endtask

  task automatic write_cfg(input bit en, input int l);
    @(negedge safe_clk); we = 1; irq_en_w = en; lim_w = 8'(l);
    @(negedge safe_clk); we = 0;
  endtask

  task automatic clear_flag();
    @(negedge safe_clk); clr = 1;
    @(negedge safe_clk); clr = 0;
  endtask

  // safe cycles until on_safe reaches target
  task automatic wait_sel(input bit target, input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      @(posedge safe_clk); #2; n++;
      if (on_safe == target) return;
    end
    n = maxc + 1;
  endtask

  task automatic stop_main_measure(input int l, input string rid);
    int n;
    @(negedge safe_clk); main_run = 0;
    wait_sel(1, l + 40, n);
    chk(n >= l && n <= l + 7, rid, n, l);
  endtask

  task automatic restart_main();
    int n;
    @(negedge safe_clk); main_run = 1;
    wait_sel(0, 4*QUAL + 20, n);
    chk(n >= QUAL && n <= 4*QUAL + 10, "R2", n, QUAL);
  endtask

  initial begin
    #WD_NS;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, e0, lim;
    #5 rst_ni = 0;
    #60;
    // R1 reset state
    chk(on_safe == 1, "R1", on_safe, 1);
    chk(flag == 1, "R1", flag, 1);
    chk(irq == 0 && wake == 0, "R1", irq, 0);
    chk(osc_en == 1, "R1", osc_en, 1);
    @(negedge safe_clk); rst_ni = 1;
    // R7 clear ignored while safe selected (counted in qualification too)
    clr = 1; @(negedge safe_clk); clr = 0;
    #1 chk(flag == 1, "R7", flag, 1);
    wait_sel(0, 4*QUAL + 20, n);
    chk(n >= QUAL - 1 && n <= 4*QUAL + 10, "R2", n, QUAL);
    mon_on = 1;
    cyc(2);
    chk(flag == 1, "R7", flag, 1);
    clear_flag(); cyc(1);
    chk(flag == 0, "R7", flag, 0);
    // R6 follows main
    e0 = sys_edges; cyc(40);
    chk((sys_edges - e0) >= edges_exp(40, MAIN_PER) - 3 && (sys_edges - e0) <= edges_exp(40, MAIN_PER) + 3,
        "R6", sys_edges - e0, edges_exp(40, MAIN_PER));

    // R3 + R5 + R8 + R9
    write_cfg(1, 20);
    stop_main_measure(20, "R3");
    cyc(3);
    chk(flag == 1, "R7", flag, 1);
    chk(irq == 1, "R8", irq, 1);
    chk(wake == 0, "R9", wake, 0);
    @(negedge safe_clk); wait_m = 1; #1;
    chk(wake == 1, "R9", wake, 1);
    @(negedge safe_clk); wait_m = 0;
    e0 = sys_edges; cyc(40);
    chk((sys_edges - e0) >= 39 && (sys_edges - e0) <= 41, "R6", sys_edges - e0, 40);
    restart_main();
    write_cfg(0, 20); cyc(1);
    chk(flag == 1 && irq == 0, "R8", irq, 0);
    clear_flag(); cyc(1);
    chk(flag == 0, "R7", flag, 0);

    // R5 clamp
    write_cfg(1, 3);
    stop_main_measure(eff_lim(3), "R5");
    restart_main(); clear_flag();

    // R4 short gap
    write_cfg(1, 40);
    @(negedge safe_clk); main_run = 0;
    n = 0;
    for (int i = 0; i < 40 - 12; i++) begin cyc(1); if (on_safe) n++; end
    @(negedge safe_clk); main_run = 1;
    for (int i = 0; i < 12; i++) begin cyc(1); if (on_safe) n++; end
    chk(n == 0, "R4", n, 0);

    // random limits, gaps and wait levels
    for (int it = 0; it < 6; it++) begin
      int g;
      lim = 12 + int'($urandom(1234 + it) % 40);
      write_cfg(1, lim);
      g = int'($urandom % 8);
      @(negedge safe_clk); main_run = 0;
      n = 0;
      for (int i = 0; i < lim - 12 - g; i++) begin cyc(1); if (on_safe) n++; end
      @(negedge safe_clk); main_run = 1;
      cyc(10);
      chk(n == 0 && on_safe == 0, "R4", n, 0);
      stop_main_measure(lim, "R3");
      @(negedge safe_clk); wait_m = 1'($urandom % 2); #1;
      chk(wake == (irq & wait_m), "R9", wake, irq & wait_m);
      restart_main(); clear_flag();
      @(negedge safe_clk); wait_m = 0;
    end

    // R10 halt, then R11 exit without reset
    write_cfg(1, 24);
    @(negedge safe_clk); halt = 1; #1;
    chk(osc_en == 0, "R10", osc_en, 0);
    @(negedge safe_clk); main_run = 0;
    write_cfg(0, 9);
    n = 0;
    for (int i = 0; i < 60; i++) begin cyc(1); if (on_safe) n++; end
    chk(n == 0, "R10", n, 0);
    @(negedge safe_clk); halt = 0;
    wait_sel(1, 100, n);
    chk(n >= 24 && n <= 24 + 7, "R11", n, 24);
    cyc(2);
    chk(irq == 1, "R11", irq, 1);
    restart_main(); clear_flag();

    // R11 reset during halt restores defaults
    @(negedge safe_clk); halt = 1;
    cyc(3);
    @(negedge safe_clk); rst_ni = 0;
    cyc(3);
    @(negedge safe_clk); rst_ni = 1; halt = 0; #1;
    chk(osc_en == 1 && on_safe == 1, "R11", on_safe, 1);
    wait_sel(0, 4*QUAL + 20, n);
    chk(n <= 4*QUAL + 10, "R2", n, QUAL);
    stop_main_measure(LIM_DEF, "R11");
    cyc(2);
    chk(irq == 0 && flag == 1, "R11", irq, 0);
    restart_main();

    chk(runts == 0, "R6", runts, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule